// File: doc/BRIEF.md
# NMI Status and Parity-Error Aggregator

This block gathers the non-maskable interrupt causes of a chip into one status register and drives a single level-sensitive NMI request. Three causes arrive as single-cycle event inputs: an external NMI pin, a clock-generator (PLL) fault and a watchdog fault. The fourth cause is SRAM parity. Each SRAM block reports errors on its own bit of a pulse vector. Each block has a detection enable bit and a sticky per-block flag.

The three plain causes are cleared by reading the status register. The parity cause behaves differently. It survives any status read made while a per-block parity flag is still set, and it is dropped only by a status read that finds every per-block flag at zero. Software clears per-block flags by writing ones to the parity status register. The trap handler therefore clears per-block flags, re-reads the parity status register until it is zero, and then reads the NMI status once more to drop the parity cause.

All registers are `NUM_BLK` bits wide. Read data is combinational from the current flag state and is zero when no read is requested. The address map is: 0 = NMI status (bit 0 external, bit 1 PLL, bit 2 watchdog, bit 3 parity, upper bits zero, writes ignored); 1 = per-block parity flags (bit i = block i, write-one-to-clear); 2 = per-block detection enables (read/write); 3 = unmapped, reads zero.

Top module: `nmi_aggregator`

## Requirements
- R1: After reset, all status flags, all per-block parity flags and all enable bits are zero, and `nmi_req` is low.
- R2: A `par_err[i]` pulse while enable bit i is set sets per-block flag i and status bit 3 at the same clock edge.
- R3: A `par_err[i]` pulse while enable bit i is clear sets neither per-block flag i nor status bit 3.
- R4: Reading address 0 returns {0, parity, watchdog, PLL, external} in bits 3..0; address 1 returns the per-block flags; address 2 returns the enables; address 3, and any cycle without `reg_rd`, returns zero.
- R5: A read of address 0 clears status bits 0, 1 and 2 at the following edge.
- R6: A read of address 0 while any per-block parity flag is set leaves status bit 3 unchanged.
- R7: A read of address 0 while all per-block parity flags are zero, with no new enabled parity error in that cycle, clears status bit 3.
- R8: A write to address 1 clears every per-block flag whose data bit is one; zero bits leave their flags unchanged.
- R9: A source event in the same cycle as a clearing read or write leaves its flag set.
- R10: `nmi_req` is high exactly when at least one of the four status flags is set.
- R11: A read that also clears flags returns the flag values from before that clear.
- R12: Writes to address 2 load the enable bits. Writes to address 0 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt | input | 1 | External NMI event pulse |
| pll_evt | input | 1 | PLL fault event pulse |
| wdt_evt | input | 1 | Watchdog fault event pulse |
| par_err | input | NUM_BLK | Per-SRAM-block parity error pulses |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NUM_BLK | Write data |
| reg_rdata | output | NUM_BLK | Read data, same cycle as `reg_rd` |
| nmi_req | output | 1 | Combined level NMI request |

## Verification
The parity path is driven with errors on enabled and disabled blocks. This separates gating by the enable bit from gating by the block index. Status reads are issued with per-block flags still set and again after they were written clear, which distinguishes the conditional parity clear from an ordinary read-to-clear. Events are timed to coincide with clearing reads and with write-one-to-clear writes, to expose set/clear priority errors. Zero-bit and partial masks separate true write-one-to-clear from a plain overwrite. Random traffic over all four addresses, with sparse events, is checked against a bench model on every read and every cycle of `nmi_req`.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_PFLAG  = 2'd1,
    A_ENABLE = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;

  // bit positions inside the NMI status register
  localparam int ST_EXT = 0;
  localparam int ST_PLL = 1;
  localparam int ST_WDT = 2;
  localparam int ST_PAR = 3;
  localparam int ST_W   = 4;

  typedef struct packed {
    logic rd_status;
    logic rd_pflag;
    logic rd_enable;
    logic wr_pflag;
    logic wr_enable;
  } reg_strobe_t;

  // next state of a sticky flag: a set always wins over a clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/nmi_flag_cell.sv
module nmi_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import nmi_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> $past(set_i));
endmodule

// File: rtl/nmi_reg_decode.sv
module nmi_reg_decode (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [nmi_pkg::ADDR_W-1:0] addr_i,
  output nmi_pkg::reg_strobe_t   strb_o
);
  import nmi_pkg::*;

  always_comb begin
    strb_o = '0;
    unique case (reg_addr_e'(addr_i))
      A_STATUS: strb_o.rd_status = rd_i;
      A_PFLAG: begin
        strb_o.rd_pflag = rd_i;
        strb_o.wr_pflag = wr_i;
      end
      A_ENABLE: begin
        strb_o.rd_enable = rd_i;
        strb_o.wr_enable = wr_i;
      end
      default: strb_o = '0;
    endcase
  end

  // R4
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb_o.rd_status, strb_o.rd_pflag, strb_o.rd_enable}));
endmodule

// File: rtl/nmi_parity_bank.sv
module nmi_parity_bank #(
  parameter int NUM_BLK = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BLK-1:0] err_i,
  input  logic               en_wr_i,
  input  logic               flag_wr_i,
  input  logic [NUM_BLK-1:0] wdata_i,
  output logic [NUM_BLK-1:0] en_o,
  output logic [NUM_BLK-1:0] flag_o,
  output logic [NUM_BLK-1:0] hit_o
);
  logic [NUM_BLK-1:0] w1c_mask;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_o <= '0;
    else if (en_wr_i) en_o <= wdata_i;
  end

  assign hit_o    = err_i & en_o;
  assign w1c_mask = flag_wr_i ? wdata_i : '0;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    nmi_flag_cell u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hit_o[b]),
      .clr_i (w1c_mask[b]),
      .q_o   (flag_o[b])
    );

    // R3
    gated_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_i[b] && !en_o[b] && !flag_o[b]) |=> !flag_o[b]);

    // R8
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr_i && !wdata_i[b] && flag_o[b]) |=> flag_o[b]);
  end
endmodule

// File: rtl/nmi_aggregator.sv
module nmi_aggregator #(
  parameter int NUM_BLK = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ext_evt,
  input  logic                       pll_evt,
  input  logic                       wdt_evt,
  input  logic [NUM_BLK-1:0]         par_err,
  input  logic                       reg_rd,
  input  logic                       reg_wr,
  input  logic [nmi_pkg::ADDR_W-1:0] reg_addr,
  input  logic [NUM_BLK-1:0]         reg_wdata,
  output logic [NUM_BLK-1:0]         reg_rdata,
  output logic                       nmi_req
);
  import nmi_pkg::*;

  localparam int PAD_W = NUM_BLK - ST_W;

  reg_strobe_t        strb;
  logic [NUM_BLK-1:0] pen, pflag, phit;
  logic [ST_W-1:0]    status;
  logic               par_any_hit;
  logic               pflags_clear;
  logic               par_clr;

  nmi_reg_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_i   (reg_rd),
    .wr_i   (reg_wr),
    .addr_i (reg_addr),
    .strb_o (strb)
  );

  nmi_parity_bank #(.NUM_BLK(NUM_BLK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_i     (par_err),
    .en_wr_i   (strb.wr_enable),
    .flag_wr_i (strb.wr_pflag),
    .wdata_i   (reg_wdata),
    .en_o      (pen),
    .flag_o    (pflag),
    .hit_o     (phit)
  );

  nmi_flag_cell u_ext (.clk(clk), .rst_n(rst_n), .set_i(ext_evt),
                       .clr_i(strb.rd_status), .q_o(status[ST_EXT]));
  nmi_flag_cell u_pll (.clk(clk), .rst_n(rst_n), .set_i(pll_evt),
                       .clr_i(strb.rd_status), .q_o(status[ST_PLL]));
  nmi_flag_cell u_wdt (.clk(clk), .rst_n(rst_n), .set_i(wdt_evt),
                       .clr_i(strb.rd_status), .q_o(status[ST_WDT]));

  assign par_any_hit  = |phit;
  assign pflags_clear = (pflag == '0);
  assign par_clr      = strb.rd_status & pflags_clear;

  nmi_flag_cell u_par (.clk(clk), .rst_n(rst_n), .set_i(par_any_hit),
                       .clr_i(par_clr), .q_o(status[ST_PAR]));

  always_comb begin
    reg_rdata = '0;
    if (strb.rd_status)      reg_rdata = {{PAD_W{1'b0}}, status};
    else if (strb.rd_pflag)  reg_rdata = pflag;
    else if (strb.rd_enable) reg_rdata = pen;
  end

  assign nmi_req = |status;

  // R5
  ext_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rd_status && !ext_evt) |=> !status[ST_EXT]);

  // R6
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rd_status && status[ST_PAR] && !pflags_clear) |=> status[ST_PAR]);

  // R7
  par_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rd_status && pflags_clear && !par_any_hit) |=> !status[ST_PAR]);

  // R2
  par_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_any_hit |=> (status[ST_PAR] && (pflag != '0)));

  // R10
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt || pll_evt || wdt_evt || par_any_hit) |=> nmi_req);

  // R12
  status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STATUS && !reg_rd && !ext_evt && !pll_evt
     && !wdt_evt && !par_any_hit) |=> $stable(status));

  initial begin
    // R4
    width_ok_chk: assert (NUM_BLK >= ST_W);
  end
endmodule

// File: tb/tb_nmi_aggregator.sv
module tb_nmi_aggregator;
  localparam int NB  = 8;
  localparam int CLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_evt = 0, pll_evt = 0, wdt_evt = 0;
  logic [NB-1:0] par_err = '0;
  logic reg_rd = 0, reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [NB-1:0] reg_wdata = '0;
  logic [NB-1:0] reg_rdata;
  logic nmi_req;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic m_ext, m_pll, m_wdt, m_par;
  logic [NB-1:0] m_pf, m_en;

  always #(CLK/2) clk = ~clk;

  nmi_aggregator #(.NUM_BLK(NB)) dut (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .pll_evt(pll_evt),
    .wdt_evt(wdt_evt), .par_err(par_err), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_req(nmi_req)
  );

  function automatic logic [NB-1:0] exp_read(input logic rd, input logic [1:0] a);
    if (!rd) return '0;
    case (a)
      2'd0:    return {{(NB-4){1'b0}}, m_par, m_wdt, m_pll, m_ext};
      2'd1:    return m_pf;
      2'd2:    return m_en;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic rs;
    logic [NB-1:0] hit, mask;
    rs   = reg_rd && reg_addr == 2'd0;
    hit  = par_err & m_en;
    mask = (reg_wr && reg_addr == 2'd1) ? reg_wdata : '0;
    if (hit != '0)                m_par = 1'b1;
    else if (rs && m_pf == '0)    m_par = 1'b0;
    m_ext = ext_evt | (m_ext & ~rs);
    m_pll = pll_evt | (m_pll & ~rs);
    m_wdt = wdt_evt | (m_wdt & ~rs);
    m_pf  = hit | (m_pf & ~mask);
    if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata;
  endtask

  // one bus cycle: drive at negedge, check read data, then clock the model
  task automatic cyc(input string tag, input logic rd, input logic wr, input logic [1:0] a,
                     input logic [NB-1:0] wd, input logic e, input logic p,
                     input logic w, input logic [NB-1:0] pe);
    @(negedge clk);
    chk("R10 nmi_req", {{(NB-1){1'b0}}, nmi_req},
        {{(NB-1){1'b0}}, (m_ext | m_pll | m_wdt | m_par)});
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    ext_evt = e; pll_evt = p; wdt_evt = w; par_err = pe;
    #1;
    chk(tag, reg_rdata, exp_read(rd, a));
    @(posedge clk);
    model_step();
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    cyc(tag, 1, 0, a, '0, 0, 0, 0, '0);
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [NB-1:0] d);
    cyc(tag, 0, 1, a, d, 0, 0, 0, '0);
  endtask

  initial begin
    #(CLK*200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_ext = 0; m_pll = 0; m_wdt = 0; m_par = 0; m_pf = '0; m_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 nmi_req", {{(NB-1){1'b0}}, nmi_req}, '0);
    rd("R1 status", 2'd0);
    rd("R1 pflag", 2'd1);
    rd("R1 enable", 2'd2);
    // R12 enable write and ignored status write
    wr("R12 en write", 2'd2, 8'h05);
    rd("R12 en read", 2'd2);
    chk("R12 en literal", reg_rdata, 8'h05);
    wr("R12 status write", 2'd0, 8'hFF);
    rd("R12 status unchanged", 2'd0);
    // R4 unmapped address and idle bus
    rd("R4 unmapped", 2'd3);
    // R3 disabled block
    cyc("R3 err", 0, 0, 2'd0, '0, 0, 0, 0, 8'h02);
    rd("R3 pflag", 2'd1);
    rd("R3 status", 2'd0);
    // R2 enabled block
    cyc("R2 err", 0, 0, 2'd0, '0, 0, 0, 0, 8'h04);
    rd("R2 pflag", 2'd1);
    chk("R2 pflag literal", reg_rdata, 8'h04);
    // R6 parity survives status reads while flag set
    rd("R6 status first", 2'd0);
    chk("R6 literal", reg_rdata, 8'h08);
    rd("R6 status again", 2'd0);
    // R8 zero mask then real clear
    wr("R8 w1c zero", 2'd1, 8'h00);
    rd("R8 kept", 2'd1);
    wr("R8 w1c", 2'd1, 8'h04);
    rd("R8 cleared", 2'd1);
    // R7 / R11: read returns pre-clear value, then clear visible
    rd("R11 status", 2'd0);
    chk("R11 literal", reg_rdata, 8'h08);
    rd("R7 status", 2'd0);
    chk("R7 literal", reg_rdata, 8'h00);
    // R5 plain causes
    cyc("R5 events", 0, 0, 2'd0, '0, 1, 1, 1, '0);
    rd("R5 status", 2'd0);
    chk("R5 literal", reg_rdata, 8'h07);
    rd("R5 cleared", 2'd0);
    // R9 event collides with clearing read / write
    cyc("R9 ext", 0, 0, 2'd0, '0, 1, 0, 0, '0);
    cyc("R9 read+evt", 1, 0, 2'd0, '0, 1, 0, 0, '0);
    rd("R9 ext kept", 2'd0);
    cyc("R9 perr", 0, 0, 2'd0, '0, 0, 0, 0, 8'h01);
    cyc("R9 w1c+perr", 0, 1, 2'd1, 8'h01, 0, 0, 0, 8'h01);
    rd("R9 pflag kept", 2'd1);
    chk("R9 literal", reg_rdata, 8'h01);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic r, w;
      r = ($urandom % 3) == 0;
      w = !r && ($urandom % 4) == 0;
      cyc("R4/R11 random read", r, w, 2'($urandom), NB'($urandom),
          ($urandom % 20) == 0, ($urandom % 20) == 0, ($urandom % 20) == 0,
          (($urandom % 8) == 0) ? NB'($urandom) : '0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule